// File: doc/BRIEF.md
# Per-Channel Digital Input Debounce Filter

This block sits between the synchronised input pins of a bank of digital ports and the logic that reads them back or watches them for edges. For each channel it can hold back a change of level until the new level has stayed put for a programmed number of time-base ticks. The ticks mark 200 ns each. Short pulses and contact bounce are removed this way. A channel that is not selected for filtering passes its raw level straight through, after one register stage.

One interval register serves every channel of every port. Each port of eight channels has its own enable byte, so filtered and unfiltered channels can share a port. Writes arrive as simple strobes with data. The interval is taken from the low 20 bits of a 32-bit write. After reset the interval is zero and every enable is clear, so the block starts as a plain one-cycle pipeline.

Top module: `glitch_filter`

## Requirements
- R1: While reset is asserted, every filtered output bit reads 0.
- R2: A channel whose enable bit is 0 drives its output with the raw input value sampled one clock earlier, whatever the interval holds.
- R3: An enabled channel behaves exactly as in R2 while the programmed interval is zero.
- R4: With an interval N ≥ 1, an enabled channel whose raw level differs from its output takes the new level on the clock edge of the N-th tick. The level must have stayed steady since the first of those ticks. The output does not change on any earlier tick.
- R5: If the raw level of an enabled channel returns to the output level before N ticks have elapsed, the pending count is discarded. A later change then needs a full N ticks again.
- R6: Channel c is enabled by bit (c mod 8) of the enable byte of port (c div 8). Channels in the same port with different enable bits behave independently.
- R7: Writing the interval register restarts the count of every enabled channel. A channel that had already counted some ticks needs N fresh ticks after the write.
- R8: The interval is bits 19:0 of the write data. Bits 31:20 are ignored.
- R9: In cycles without a tick, no enabled channel with a nonzero interval changes its output.
- R10: An enable write strobe for one port leaves the enable bytes of all other ports unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle strobe every 200 ns time-base period |
| raw_in | input | NUM_PORTS*8 | Synchronised raw channel levels; channel c at bit c |
| ivl_wr | input | 1 | Write strobe for the shared interval register |
| ivl_wdata | input | 32 | Interval write data; bits 19:0 used |
| en_wr | input | NUM_PORTS | Per-port write strobe for the enable byte |
| en_wdata | input | 8 | Enable byte data; bit i enables channel i of the port |
| filt_out | output | NUM_PORTS*8 | Filtered channel levels |

## Verification
The bench builds the block with two ports and the full 20-bit interval field. Two ports make it possible to see that an enable write lands only on the addressed port. The ticks are driven by hand, so intervals of two to four ticks let the bench probe the exact tick on which a level is released, one tick before it, and the restart caused by a glitch or by an interval rewrite. Those checks need only a few cycles each. The bench writes a value with a bit set above bit 19. This shows that only the 20-bit field sets the interval, and it would expose a counter that took the whole word.

// File: rtl/gf_pkg.sv
package gf_pkg;

    localparam int unsigned CH_PER_PORT = 8;
    localparam int unsigned BUS_W       = 32;

    typedef enum logic [1:0] {
        CH_BYPASS = 2'd0,
        CH_IDLE   = 2'd1,
        CH_COUNT  = 2'd2
    } ch_mode_e;

endpackage

// File: rtl/gf_interval_reg.sv
module gf_interval_reg #(
    parameter int unsigned IVL_W = 20,
    parameter int unsigned BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [BUS_W-1:0] wdata,
    output logic [IVL_W-1:0] ivl,
    output logic             restart
);

    typedef struct packed {
        logic [IVL_W-1:0] val;
    } ivl_state_t;

    ivl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.val = wdata[IVL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ivl     = st_q.val;
    assign restart = wr;

endmodule

// File: rtl/gf_enable_bank.sv
module gf_enable_bank #(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned PORT_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        wr,
    input  logic [PORT_W-1:0]           wdata,
    output logic [NUM_PORTS*PORT_W-1:0] en_vec
);

    typedef struct packed {
        logic [NUM_PORTS-1:0][PORT_W-1:0] bytes;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (wr[p]) begin
                st_d.bytes[p] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_vec = st_q.bytes;

endmodule

// File: rtl/gf_channel.sv
module gf_channel
    import gf_pkg::*;
#(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic             filt_en,
    input  logic [CNT_W-1:0] ivl,
    input  logic             restart,
    input  logic             tick,
    output logic             filt
);

    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } ch_state_t;

    ch_state_t st_d, st_q;
    ch_mode_e  mode;

    // Classify the channel for this cycle.
    always_comb begin
        if (!filt_en || ivl == '0) begin
            mode = CH_BYPASS;
        end else if (raw == st_q.lvl || restart) begin
            mode = CH_IDLE;
        end else begin
            mode = CH_COUNT;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (mode)
            CH_BYPASS: begin
                st_d.lvl = raw;
                st_d.cnt = '0;
            end
            CH_IDLE: begin
                st_d.cnt = '0;
            end
            CH_COUNT: begin
                if (tick) begin
                    if (st_q.cnt >= ivl - CNT_W'(1)) begin
                        st_d.lvl = raw;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt = st_q.lvl;

endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
    import gf_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned IVL_W     = 20
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             tick,
    input  logic [NUM_PORTS*CH_PER_PORT-1:0] raw_in,
    input  logic                             ivl_wr,
    input  logic [BUS_W-1:0]                 ivl_wdata,
    input  logic [NUM_PORTS-1:0]             en_wr,
    input  logic [CH_PER_PORT-1:0]           en_wdata,
    output logic [NUM_PORTS*CH_PER_PORT-1:0] filt_out
);

    localparam int unsigned NUM_CH = NUM_PORTS * CH_PER_PORT;

    logic [IVL_W-1:0]  ivl_q;
    logic              restart;
    logic [NUM_CH-1:0] en_vec;

    gf_interval_reg #(
        .IVL_W (IVL_W),
        .BUS_W (BUS_W)
    ) ivl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ivl_wr),
        .wdata   (ivl_wdata),
        .ivl     (ivl_q),
        .restart (restart)
    );

    gf_enable_bank #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (CH_PER_PORT)
    ) en_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (en_wr),
        .wdata  (en_wdata),
        .en_vec (en_vec)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        gf_channel #(
            .CNT_W (IVL_W)
        ) ch_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw     (raw_in[c]),
            .filt_en (en_vec[c]),
            .ivl     (ivl_q),
            .restart (restart),
            .tick    (tick),
            .filt    (filt_out[c])
        );
    end

endmodule

// File: rtl/gf_checker.sv
module gf_checker #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned IVL_W  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              ivl_wr,
    input logic [NUM_CH-1:0] raw_in,
    input logic [NUM_CH-1:0] filt_out,
    input logic [NUM_CH-1:0] en_vec,
    input logic [IVL_W-1:0]  ivl_q
);

    assert_bypass_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((filt_out ^ $past(raw_in)) & ~$past(en_vec)) == '0)
        else $error("disabled channel did not follow raw input");

    assert_zero_interval_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_q == '0) |=> filt_out == $past(raw_in))
        else $error("zero interval did not pass through");

    assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && ivl_q != '0) |=> ((filt_out ^ $past(filt_out)) & $past(en_vec)) == '0)
        else $error("filtered channel changed without a tick");

    assert_restart_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_wr && ivl_q != '0) |=> ((filt_out ^ $past(filt_out)) & $past(en_vec)) == '0)
        else $error("filtered channel released on interval write");

endmodule

bind glitch_filter gf_checker #(
    .NUM_CH (NUM_CH),
    .IVL_W  (IVL_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .ivl_wr   (ivl_wr),
    .raw_in   (raw_in),
    .filt_out (filt_out),
    .en_vec   (en_vec),
    .ivl_q    (ivl_q)
);

// File: tb/glitch_filter_tb.sv
module glitch_filter_tb_top;

    localparam int NP = 2;
    localparam int NC = NP * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [NC-1:0] raw_in = '0;
    logic          ivl_wr = 1'b0;
    logic [31:0]   ivl_wdata = '0;
    logic [NP-1:0] en_wr = '0;
    logic [7:0]    en_wdata = '0;
    logic [NC-1:0] filt_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    glitch_filter #(.NUM_PORTS(NP), .IVL_W(20)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .raw_in    (raw_in),
        .ivl_wr    (ivl_wr),
        .ivl_wdata (ivl_wdata),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .filt_out  (filt_out)
    );

    task automatic chk(string tag, logic [NC-1:0] act, logic [NC-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clocks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(int n);
        repeat (n) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic set_ivl(logic [31:0] v);
        @(negedge clk) begin ivl_wr = 1'b1; ivl_wdata = v; end
        @(negedge clk) ivl_wr = 1'b0;
    endtask

    task automatic set_en(int port, logic [7:0] v);
        @(negedge clk) begin en_wr = '0; en_wr[port] = 1'b1; en_wdata = v; end
        @(negedge clk) en_wr = '0;
    endtask

    // Return to a known output with pass-through, then apply the setup.
    task automatic settle(logic [NC-1:0] lvl);
        set_ivl(32'd0);
        @(negedge clk) raw_in = lvl;
        clocks(2);
    endtask

    task automatic t_reset;
        raw_in = '1;
        clocks(3);
        chk("R1 reset output", filt_out, '0);
        @(negedge clk) rst_n = 1'b1;
        clocks(2);
        chk("R1 default pass-through", filt_out, '1);
    endtask

    task automatic t_bypass;
        set_ivl(32'd5);
        @(negedge clk) raw_in = 16'h3C96;
        @(negedge clk);
        chk("R2 disabled follows raw", filt_out, 16'h3C96);
        @(negedge clk) raw_in = 16'hA001;
        @(negedge clk);
        chk("R2 disabled second pattern", filt_out, 16'hA001);
    endtask

    task automatic t_zero_ivl;
        settle('0);
        set_en(0, 8'hFF);
        @(negedge clk) raw_in = 16'h005A;
        @(negedge clk);
        chk("R3 enabled zero interval", filt_out, 16'h005A);
    endtask

    task automatic t_release;
        settle('0);
        set_en(0, 8'hFF);
        set_ivl(32'd4);
        @(negedge clk) raw_in = 16'h00A5;
        ticks(3);
        chk("R4 held before last tick", filt_out, 16'h0000);
        ticks(1);
        chk("R4 released on tick N", filt_out, 16'h00A5);
    endtask

    task automatic t_glitch;
        // continues from t_release: output 0x00A5, interval 4
        @(negedge clk) raw_in = 16'h0000;
        ticks(2);
        @(negedge clk) raw_in = 16'h00A5;
        clocks(2);
        @(negedge clk) raw_in = 16'h0000;
        ticks(3);
        chk("R5 glitch count discarded", filt_out, 16'h00A5);
        ticks(1);
        chk("R5 full interval after glitch", filt_out, 16'h0000);
    endtask

    task automatic t_mixed;
        settle('0);
        set_en(0, 8'h0F);
        set_ivl(32'd4);
        @(negedge clk) raw_in = 16'h00FF;
        @(negedge clk);
        chk("R6 unfiltered bits pass", filt_out, 16'h00F0);
        ticks(4);
        chk("R6 filtered bits released", filt_out, 16'h00FF);
    endtask

    task automatic t_restart;
        // continues from t_mixed: output 0x00FF, enable 0x0F, interval 4
        @(negedge clk) raw_in = 16'h0000;
        @(negedge clk);
        ticks(3);
        chk("R7 partial count", filt_out, 16'h000F);
        set_ivl(32'd4);
        ticks(3);
        chk("R7 count restarted by write", filt_out, 16'h000F);
        ticks(1);
        chk("R7 released after fresh interval", filt_out, 16'h0000);
    endtask

    task automatic t_upper_bits;
        settle('0);
        set_en(0, 8'hFF);
        set_ivl(32'h0010_0002);
        @(negedge clk) raw_in = 16'h00FF;
        @(negedge clk);
        chk("R8 not pass-through", filt_out, 16'h0000);
        ticks(1);
        chk("R8 one tick short", filt_out, 16'h0000);
        ticks(1);
        chk("R8 interval is low field", filt_out, 16'h00FF);
    endtask

    task automatic t_no_tick;
        settle('0);
        set_en(0, 8'hFF);
        set_ivl(32'd2);
        @(negedge clk) raw_in = 16'h0081;
        clocks(50);
        chk("R9 no change without tick", filt_out, 16'h0000);
    endtask

    task automatic t_port_select;
        settle('0);
        set_en(0, 8'h00);
        set_en(1, 8'hFF);
        set_ivl(32'd3);
        @(negedge clk) raw_in = 16'hFFFF;
        @(negedge clk);
        chk("R10 port 0 untouched by port 1 write", filt_out, 16'h00FF);
        ticks(3);
        chk("R10 port 1 filtered", filt_out, 16'hFFFF);
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_zero_ivl();
        t_release();
        t_glitch();
        t_mixed();
        t_restart();
        t_upper_bits();
        t_no_tick();
        t_port_select();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule